// File: doc/BRIEF.md
# Dual-Timer Host Register Interface

This block is the host-facing register bank of a two-channel timer/counter peripheral. A 32-bit host reaches it through a Wishbone slave port. Six byte-wide registers sit behind that port: a control byte, a mode byte, and a low and a high count byte for each of timers A and B. Only the low 8 bits of the data bus carry register contents. The register values leave the block as registered outputs that feed the counting engine. The counting engine itself is not part of this block.

Each register has its own write rule. The host can change only the upper nibble of the control byte. The lower nibble of the control byte is written by a hardware update port that the counting engine drives. When a timer is in its 13-bit mode (mode 0), a write to that timer's low count byte keeps 5 bits and forces the rest to zero. Reads always return the complete byte.

Host accesses are handled by a two-state machine:
- `S_WAIT` waits for a request. The transition `ACCEPT` (CYC and STB both high) commits any write and captures the read data, and the machine moves to `S_RESP`.
- `S_RESP` drives ACK for one cycle. The transition `RELEASE` always returns the machine to `S_WAIT`.

Top module: `wbt_regif`

## Requirements
- R1: A synchronous reset clears the control, mode and all four count registers to zero, and holds ACK low.
- R2: A request (CYC and STB both high while idle) is acknowledged in the next cycle. ACK stays high for exactly one cycle per access.
- R3: A host write to the control register (word offset 0) loads data bits 7..4 into control bits 7..4. Control bits 3..0 keep their value.
- R4: When `hw_upd_en` is high, control bits 3..0 take `hw_upd_val` at the clock edge. A host control write in the same cycle still changes only bits 7..4.
- R5: A write to the mode register (offset 1) loads all 8 bits. Mode bits 1..0 select timer A's mode, and mode bits 5..4 select timer B's mode.
- R6: If the owning timer's mode is 0 before the write, a write to that timer's low count register loads data bits 4..0 and forces bits 7..5 to zero. Timer A's low register is at offset 2 and timer B's is at offset 3.
- R7: If the owning timer's mode is 1, 2 or 3, a write to that timer's low count register loads all 8 bits.
- R8: A write to a high count register (timer A at offset 4, timer B at offset 5) loads all 8 bits in every mode.
- R9: A read returns the register's full current 8-bit value on data bits 7..4 and 3..0, including the hardware-written control bits. Data bits 31..8 are zero. The read data is valid while ACK is high.
- R10: Offsets 6 and 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 3 | Register word offset |
| wb_dat_i | input | 32 | Write data (bits 7..0 used) |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| hw_upd_en | input | 1 | Hardware update strobe for control bits 3..0 |
| hw_upd_val | input | 4 | Hardware value for control bits 3..0 |
| ctrl_o | output | 8 | Control register |
| mode_o | output | 8 | Mode register |
| cnt_a_lo_o | output | 8 | Timer A low count |
| cnt_b_lo_o | output | 8 | Timer B low count |
| cnt_a_hi_o | output | 8 | Timer A high count |
| cnt_b_hi_o | output | 8 | Timer B high count |

## Verification
The hardest situation to reach is a host control write that lands in the same cycle as a hardware nibble update. Close behind it is a low count write whose masking depends on a mode field that an earlier write set to 0. Random stimulus raises `hw_upd_en` together with roughly half of the accesses and draws the mode byte often enough that both fields pass through 0. Directed sequences then force the exact collision and the mode-0 writes to both timers, and compare the results with a bench model.

// File: rtl/wbt_pkg.sv
package wbt_pkg;
    localparam int REG_W  = 8;
    localparam int BUS_W  = 32;
    localparam int ADR_W  = 3;
    localparam int NIB_W  = REG_W / 2;
    localparam int MODE_W = 2;
    localparam int MODE_A_LSB = 0;
    localparam int MODE_B_LSB = 4;
    localparam int TRUNC_W    = 5;

    localparam logic [ADR_W-1:0] OFS_CTRL = 3'd0;
    localparam logic [ADR_W-1:0] OFS_MODE = 3'd1;
    localparam logic [ADR_W-1:0] OFS_ALO  = 3'd2;
    localparam logic [ADR_W-1:0] OFS_BLO  = 3'd3;
    localparam logic [ADR_W-1:0] OFS_AHI  = 3'd4;
    localparam logic [ADR_W-1:0] OFS_BHI  = 3'd5;

    typedef enum logic {S_WAIT = 1'b0, S_RESP = 1'b1} bus_state_t;
endpackage

// File: rtl/wbt_bus_fsm.sv
module wbt_bus_fsm
    import wbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc,
    input  logic             stb,
    input  logic             we,
    input  logic [REG_W-1:0] rd_byte,
    output logic             wr_en,
    output logic [BUS_W-1:0] dat_o,
    output logic             ack
);
    bus_state_t state_q, state_d;
    logic       accept;

    assign accept = (state_q == S_WAIT) && cyc && stb;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_WAIT: if (accept) state_d = S_RESP;
            S_RESP: state_d = S_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_WAIT;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dat_o <= '0;
        end else if (accept && !we) begin
            dat_o <= {{(BUS_W-REG_W){1'b0}}, rd_byte};
        end
    end

    assign wr_en = accept && we;
    assign ack   = (state_q == S_RESP);

    // R2
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    // R2
    ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc && stb && !ack) |=> ack);
endmodule

// File: rtl/wbt_regbank.sv
module wbt_regbank
    import wbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [ADR_W-1:0] wr_adr,
    input  logic [REG_W-1:0] wr_byte,
    input  logic             hw_en,
    input  logic [NIB_W-1:0] hw_val,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] mode_q,
    output logic [REG_W-1:0] alo_q,
    output logic [REG_W-1:0] blo_q,
    output logic [REG_W-1:0] ahi_q,
    output logic [REG_W-1:0] bhi_q
);
    logic a_narrow, b_narrow;
    logic [REG_W-1:0] trunc_byte;

    assign a_narrow   = (mode_q[MODE_A_LSB +: MODE_W] == '0);
    assign b_narrow   = (mode_q[MODE_B_LSB +: MODE_W] == '0);
    assign trunc_byte = {{(REG_W-TRUNC_W){1'b0}}, wr_byte[TRUNC_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mode_q <= '0;
            alo_q  <= '0;
            blo_q  <= '0;
            ahi_q  <= '0;
            bhi_q  <= '0;
        end else begin
            if (hw_en) ctrl_q[NIB_W-1:0] <= hw_val;
            if (wr_en) begin
                unique case (wr_adr)
                    OFS_CTRL: ctrl_q[REG_W-1:NIB_W] <= wr_byte[REG_W-1:NIB_W];
                    OFS_MODE: mode_q <= wr_byte;
                    OFS_ALO:  alo_q  <= a_narrow ? trunc_byte : wr_byte;
                    OFS_BLO:  blo_q  <= b_narrow ? trunc_byte : wr_byte;
                    OFS_AHI:  ahi_q  <= wr_byte;
                    OFS_BHI:  bhi_q  <= wr_byte;
                    default:  ;
                endcase
            end
        end
    end

    // R3
    ctrl_low_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_adr == OFS_CTRL && !hw_en) |=> $stable(ctrl_q[NIB_W-1:0]));
    // R4
    hw_nibble_chk: assert property (@(posedge clk) disable iff (rst)
        hw_en |=> ctrl_q[NIB_W-1:0] == $past(hw_val));
    // R6
    a_trunc_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_adr == OFS_ALO && a_narrow) |=> alo_q[REG_W-1:TRUNC_W] == '0);
    // R10
    unmapped_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_adr > OFS_BHI && !hw_en) |=>
            ($stable(ctrl_q) && $stable(mode_q) && $stable(alo_q) &&
             $stable(blo_q) && $stable(ahi_q) && $stable(bhi_q)));
endmodule

// File: rtl/wbt_rdmux.sv
module wbt_rdmux
    import wbt_pkg::*;
(
    input  logic [ADR_W-1:0] adr,
    input  logic [REG_W-1:0] ctrl_q,
    input  logic [REG_W-1:0] mode_q,
    input  logic [REG_W-1:0] alo_q,
    input  logic [REG_W-1:0] blo_q,
    input  logic [REG_W-1:0] ahi_q,
    input  logic [REG_W-1:0] bhi_q,
    output logic [REG_W-1:0] rd_byte
);
    always_comb begin
        unique case (adr)
            OFS_CTRL: rd_byte = ctrl_q;
            OFS_MODE: rd_byte = mode_q;
            OFS_ALO:  rd_byte = alo_q;
            OFS_BLO:  rd_byte = blo_q;
            OFS_AHI:  rd_byte = ahi_q;
            OFS_BHI:  rd_byte = bhi_q;
            default:  rd_byte = '0;
        endcase
    end
endmodule

// File: rtl/wbt_regif.sv
module wbt_regif
    import wbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wb_cyc_i,
    input  logic             wb_stb_i,
    input  logic             wb_we_i,
    input  logic [ADR_W-1:0] wb_adr_i,
    input  logic [BUS_W-1:0] wb_dat_i,
    output logic [BUS_W-1:0] wb_dat_o,
    output logic             wb_ack_o,
    input  logic             hw_upd_en,
    input  logic [NIB_W-1:0] hw_upd_val,
    output logic [REG_W-1:0] ctrl_o,
    output logic [REG_W-1:0] mode_o,
    output logic [REG_W-1:0] cnt_a_lo_o,
    output logic [REG_W-1:0] cnt_b_lo_o,
    output logic [REG_W-1:0] cnt_a_hi_o,
    output logic [REG_W-1:0] cnt_b_hi_o
);
    logic             wr_en;
    logic [REG_W-1:0] rd_byte;

    wbt_bus_fsm u_fsm (
        .clk(clk), .rst(rst), .cyc(wb_cyc_i), .stb(wb_stb_i), .we(wb_we_i),
        .rd_byte(rd_byte), .wr_en(wr_en), .dat_o(wb_dat_o), .ack(wb_ack_o)
    );

    wbt_regbank u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_adr(wb_adr_i),
        .wr_byte(wb_dat_i[REG_W-1:0]), .hw_en(hw_upd_en), .hw_val(hw_upd_val),
        .ctrl_q(ctrl_o), .mode_q(mode_o), .alo_q(cnt_a_lo_o), .blo_q(cnt_b_lo_o),
        .ahi_q(cnt_a_hi_o), .bhi_q(cnt_b_hi_o)
    );

    wbt_rdmux u_rd (
        .adr(wb_adr_i), .ctrl_q(ctrl_o), .mode_q(mode_o), .alo_q(cnt_a_lo_o),
        .blo_q(cnt_b_lo_o), .ahi_q(cnt_a_hi_o), .bhi_q(cnt_b_hi_o), .rd_byte(rd_byte)
    );

    // R1
    rst_ack_chk: assert property (@(posedge clk) rst |=> !wb_ack_o);
endmodule

// File: tb/wbt_regif_tb.sv
module wbt_regif_tb;
    logic        clk = 0;
    logic        rst;
    logic        cyc, stb, we;
    logic [2:0]  adr;
    logic [31:0] dat_i;
    logic [31:0] dat_o;
    logic        ack;
    logic        hw_en;
    logic [3:0]  hw_val;
    logic [7:0]  r_ctrl, r_mode, r_alo, r_blo, r_ahi, r_bhi;

    int tests = 0, fails = 0;
    logic [7:0] m [0:5];

    always #4 clk = ~clk;

    wbt_regif u_dut (
        .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_dat_i(dat_i), .wb_dat_o(dat_o), .wb_ack_o(ack),
        .hw_upd_en(hw_en), .hw_upd_val(hw_val),
        .ctrl_o(r_ctrl), .mode_o(r_mode), .cnt_a_lo_o(r_alo), .cnt_b_lo_o(r_blo),
        .cnt_a_hi_o(r_ahi), .cnt_b_hi_o(r_bhi)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wr_rule(input logic [2:0] a, input logic [7:0] old,
                                           input logic [7:0] mode, input logic [7:0] d);
        case (a)
            3'd0: return {d[7:4], old[3:0]};
            3'd2: return (mode[1:0] == 2'd0) ? {3'b0, d[4:0]} : d;
            3'd3: return (mode[5:4] == 2'd0) ? {3'b0, d[4:0]} : d;
            default: return d;
        endcase
    endfunction

    task automatic check_regs(input string req);
        check({req, " ctrl"}, {24'd0, r_ctrl}, {24'd0, m[0]});
        check({req, " mode"}, {24'd0, r_mode}, {24'd0, m[1]});
        check({req, " alo"},  {24'd0, r_alo},  {24'd0, m[2]});
        check({req, " blo"},  {24'd0, r_blo},  {24'd0, m[3]});
        check({req, " ahi"},  {24'd0, r_ahi},  {24'd0, m[4]});
        check({req, " bhi"},  {24'd0, r_bhi},  {24'd0, m[5]});
    endtask

    // one access; inputs driven at negedge, checks one negedge later
    task automatic access(input logic w, input logic [2:0] a, input logic [31:0] d,
                          input logic he, input logic [3:0] hv, input string req);
        logic [7:0] rexp;
        rexp = (a <= 3'd5) ? m[a] : 8'h00;
        cyc = 1; stb = 1; we = w; adr = a; dat_i = d; hw_en = he; hw_val = hv;
        @(negedge clk);
        if (w && a <= 3'd5) m[a] = wr_rule(a, m[a], m[1], d[7:0]);
        if (he) m[0][3:0] = hv;
        check({"R2 ack ", req}, {31'd0, ack}, 32'd1);
        if (!w) check({"R9 read ", req}, dat_o, {24'd0, rexp});
        cyc = 0; stb = 0; we = 0; hw_en = 0;
        @(negedge clk);
        check({"R2 single ", req}, {31'd0, ack}, 32'd0);
    endtask

    initial begin
        cyc = 0; stb = 0; we = 0; adr = 0; dat_i = 0; hw_en = 0; hw_val = 0;
        for (int i = 0; i < 6; i++) m[i] = 8'h00;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 ack", {31'd0, ack}, 32'd0);
        check_regs("R1");

        // R3: host write to ctrl affects only upper nibble
        access(1, 3'd0, 32'hFFFF_FFFF, 0, 4'h0, "R3");
        check_regs("R3");
        // R4: hw update alone, then collision with a host write
        access(0, 3'd1, 0, 1, 4'hA, "R4 hw");
        check_regs("R4");
        access(1, 3'd0, 32'h0000_0035, 1, 4'h6, "R4 clash");
        check_regs("R4 clash");
        access(0, 3'd0, 0, 0, 0, "R9 ctrl full");
        // R6: mode 0 on both timers
        access(1, 3'd2, 32'h0000_00FF, 0, 0, "R6 a");
        access(1, 3'd3, 32'h0000_00EE, 0, 0, "R6 b");
        check_regs("R6");
        // R5/R7: timer A mode 1, timer B still 0
        access(1, 3'd1, 32'hABCD_0001, 0, 0, "R5");
        access(1, 3'd2, 32'h0000_00FF, 0, 0, "R7 a");
        access(1, 3'd3, 32'h0000_00FF, 0, 0, "R6 b still");
        check_regs("R7");
        // R8: high regs full regardless of mode
        access(1, 3'd4, 32'h0000_00E7, 0, 0, "R8 a");
        access(1, 3'd5, 32'h0000_00F9, 0, 0, "R8 b");
        check_regs("R8");
        // R10: unmapped offsets
        access(1, 3'd6, 32'h0000_0077, 0, 0, "R10 w6");
        access(1, 3'd7, 32'h0000_0088, 0, 0, "R10 w7");
        check_regs("R10");
        access(0, 3'd7, 0, 0, 0, "R10 r7");

        // random phase, fixed seed
        void'($urandom(32'd1234));
        for (int n = 0; n < 400; n++) begin
            logic [2:0]  ra;
            logic [31:0] rd;
            ra = 3'($urandom_range(0, 7));
            rd = $urandom;
            if (($urandom & 3) == 0) rd[1:0] = 2'd0;
            if (($urandom & 3) == 0) rd[5:4] = 2'd0;
            access(1'($urandom & 1), ra, rd, 1'($urandom & 1), 4'($urandom), "R9 rand");
            check_regs("R7 rand");
        end

        // R1: reset clears after activity
        rst = 1;
        @(negedge clk);
        rst = 0;
        for (int i = 0; i < 6; i++) m[i] = 8'h00;
        check_regs("R1 again");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule